// File: doc/BRIEF.md
# Streaming-Write Receive Sink

This block sits on the user side of a packet receiver and takes in streaming-write packets delivered over two valid/ready streams: a 115-bit header stream and a 128-bit payload stream. The header is taken in the same cycle as the first payload beat. The block decodes the header and checks that it is a supported streaming write. It then places the payload bytes into a local byte-addressable buffer at the address the header carries. That address is in 8-byte units, so the buffer byte address is eight times the address field, wrapping modulo the buffer size.

On the last payload beat the sender states, in two-byte segments, how much of the least significant end of the beat is unused. The block uses that count to trim the write. It also uses it to cross-check the header's 9-bit byte count against the bytes actually received. Each packet ends with a one-cycle completion pulse. That pulse is joined by a size-error pulse or a header-error pulse when a check fails. A packet with a bad header is drained and none of its bytes are stored. A combinational read port lets the surrounding logic fetch the stored bytes.

Top module: `swr_rx_sink`

## Requirements
- R1: While idle, the header and the payload beat flagged start-of-packet are accepted together in one cycle. `hdr_ready` is high only when `pl_valid` and `pl_sop` are high, and `pl_ready` is high only when `hdr_valid` and `pl_sop` are high. Neither stream is accepted alone.
- R2: After a payload beat without end-of-packet has been accepted, `hdr_ready` stays low and `pl_ready` stays high until the end-of-packet beat has been accepted.
- R3: The buffer byte address of a packet's first byte is 8 times the header address field (bits [63:35]), modulo `BUF_BYTES`. Byte j of beat k, where j=0 is bits [127:120], goes to that base plus 16k+j, also modulo `BUF_BYTES`.
- R4: On the end-of-packet beat, an empty value e (`pl_empty`, 0..7) leaves only the 16-2e most significant bytes valid. Only those bytes are written, and the buffer bytes the remaining lanes would have covered keep their earlier contents.
- R5: `done` is high for exactly the one cycle following the clock edge that accepts an end-of-packet beat.
- R6: For a packet with an accepted header, the received count is 16 times the number of beats minus 2 times the last empty value. When that count differs from header bits [114:106], `size_err` pulses together with `done`. The bytes are still written.
- R7: A format type (header bits [99:96]) other than 6 makes `hdr_err` pulse with `done`. No byte of that packet is written.
- R8: A header with the virtual-channel bit (bit [105]) set makes `hdr_err` pulse with `done`. No byte of that packet is written.
- R9: With transport type (bits [101:100]) equal to 0, a non-zero upper byte of the destination ID (bits [95:88]) or of the source ID (bits [79:72]) makes `hdr_err` pulse and discards the packet. With any other transport type those upper bytes are not checked.
- R10: After reset, with no input valid, both ready outputs and all three pulse outputs are low.
- R11: `rd_data` shows the buffer byte at `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header word valid |
| hdr_ready | output | 1 | Header accepted this cycle when valid is also high |
| hdr_data | input | 115 | Header word |
| pl_valid | input | 1 | Payload beat valid |
| pl_ready | output | 1 | Payload beat accepted this cycle when valid is also high |
| pl_data | input | 128 | Payload beat, first byte in bits [127:120] |
| pl_sop | input | 1 | First beat of a packet |
| pl_eop | input | 1 | Last beat of a packet |
| pl_empty | input | 3 | Unused two-byte segments at the low end of the last beat |
| rd_addr | input | $clog2(BUF_BYTES) | Buffer read address |
| rd_data | output | 8 | Buffer byte at rd_addr |
| done | output | 1 | Packet completion pulse |
| size_err | output | 1 | Byte-count mismatch pulse |
| hdr_err | output | 1 | Unsupported or malformed header pulse |

## Verification
On every cycle, the assertions check the handshake rules and the pulses. The header is only ever taken with a start-of-packet beat, and no header is taken mid-packet. Every end-of-packet acceptance is followed by exactly one `done`. The two error pulses never appear without `done` and never together. Other behaviour can only be shown by the bench's scenarios: byte placement, trimming on the last beat, address wrap, discarding bad packets, and the exact count behind a size error. Its reference model tracks every byte written and the expected pulse in each cycle.

// File: rtl/swr_rx_sink.sv
module swr_rx_sink #(
  parameter int BUF_BYTES  = 256,
  parameter int BEAT_BYTES = 16,
  localparam int HW = 115,
  localparam int DW = 8 * BEAT_BYTES,
  localparam int EW = $clog2(BEAT_BYTES / 2),
  localparam int AW = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hdr_valid,
  output logic          hdr_ready,
  input  logic [HW-1:0] hdr_data,
  input  logic          pl_valid,
  output logic          pl_ready,
  input  logic [DW-1:0] pl_data,
  input  logic          pl_sop,
  input  logic          pl_eop,
  input  logic [EW-1:0] pl_empty,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          done,
  output logic          size_err,
  output logic          hdr_err
);
  localparam int NW = $clog2(BEAT_BYTES) + 1;
  localparam int CW = 16;

  logic [7:0] mem [BUF_BYTES];

  logic          busy, bad_q;
  logic [AW-1:0] base_q, off_q;
  logic [8:0]    size_q;
  logic [CW-1:0] cnt_q;

  wire [8:0]  in_size = hdr_data[114:106];
  wire        in_vc   = hdr_data[105];
  wire [1:0]  in_tt   = hdr_data[101:100];
  wire [3:0]  in_ft   = hdr_data[99:96];
  wire [31:0] in_byte = {hdr_data[63:35], 3'b000};
  wire        id_hi   = (hdr_data[95:88] != 8'd0) || (hdr_data[79:72] != 8'd0);
  wire        in_bad  = in_vc || (in_ft != 4'd6) || ((in_tt == 2'b00) && id_hi);

  logic unused_bits;
  assign unused_bits = ^{hdr_data[104:102], hdr_data[34:0], hdr_data[87:80],
                         hdr_data[71:64], in_byte[31:AW]};

  assign hdr_ready = !busy && pl_valid && pl_sop;
  assign pl_ready  = busy || (hdr_valid && pl_sop);
  wire pl_fire = pl_valid && pl_ready;

  wire [AW-1:0] base_now = busy ? base_q : in_byte[AW-1:0];
  wire [AW-1:0] off_now  = busy ? off_q  : '0;
  wire [8:0]    size_now = busy ? size_q : in_size;
  wire          bad_now  = busy ? bad_q  : in_bad;
  wire [CW-1:0] cnt_now  = busy ? cnt_q  : '0;

  wire [NW-1:0] nvalid = pl_eop ? NW'(BEAT_BYTES) - NW'({pl_empty, 1'b0}) : NW'(BEAT_BYTES);
  wire [CW-1:0] total  = cnt_now + CW'(nvalid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      bad_q    <= 1'b0;
      base_q   <= '0;
      off_q    <= '0;
      size_q   <= '0;
      cnt_q    <= '0;
      done     <= 1'b0;
      size_err <= 1'b0;
      hdr_err  <= 1'b0;
    end else begin
      done     <= 1'b0;
      size_err <= 1'b0;
      hdr_err  <= 1'b0;
      if (pl_fire) begin
        if (pl_eop) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          hdr_err  <= bad_now;
          size_err <= !bad_now && (total != CW'(size_now));
        end else begin
          busy   <= 1'b1;
          bad_q  <= bad_now;
          base_q <= base_now;
          off_q  <= off_now + AW'(BEAT_BYTES);
          size_q <= size_now;
          cnt_q  <= total;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < BEAT_BYTES; j++) begin
      if (pl_fire && !bad_now && (j < int'(nvalid)))
        mem[base_now + off_now + AW'(j)] <= pl_data[DW-1-8*j -: 8];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/swr_rx_sink_chk.sv
module swr_rx_sink_chk (
  input logic clk,
  input logic rst_n,
  input logic hdr_valid,
  input logic hdr_ready,
  input logic pl_valid,
  input logic pl_ready,
  input logic pl_sop,
  input logic pl_eop,
  input logic done,
  input logic size_err,
  input logic hdr_err
);
  assert_hdr_with_sop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready) |-> (pl_valid && pl_ready && pl_sop));

  assert_no_hdr_midpkt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && pl_ready && !pl_eop) |=> !hdr_ready);

  assert_eop_gives_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && pl_ready && pl_eop) |=> done);

  assert_done_needs_eop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pl_valid && pl_ready && pl_eop));

  assert_size_err_in_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> done);

  assert_hdr_err_in_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> done);

  assert_err_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(size_err && hdr_err));
endmodule

bind swr_rx_sink swr_rx_sink_chk u_chk (.*);

// File: tb/tb_swr_rx_sink.sv
`timescale 1ns/1ps
module tb_swr_rx_sink;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         hdr_valid = 0, pl_valid = 0, pl_sop = 0, pl_eop = 0;
  logic [114:0] hdr_data = '0;
  logic [127:0] pl_data = '0;
  logic [2:0]   pl_empty = '0;
  logic [7:0]   rd_addr = '0;
  logic [7:0]   rd_data;
  logic         hdr_ready, pl_ready, done, size_err, hdr_err;

  int checks = 0, errors = 0;
  bit started = 0;
  bit exp_done = 0, exp_serr = 0, exp_herr = 0;
  bit pend_done = 0, pend_serr = 0, pend_herr = 0;
  logic [7:0] ref_mem [256];
  bit         ref_known [256];

  always #2.5 clk = ~clk;

  swr_rx_sink dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && started) begin
    chk(done === exp_done, "R5 done", done, exp_done);
    chk(size_err === exp_serr, "R6 size_err", size_err, exp_serr);
    chk(hdr_err === exp_herr, "R7 R8 R9 hdr_err", hdr_err, exp_herr);
  end

  task automatic step();
    @(posedge clk); #1;
    exp_done = pend_done; exp_serr = pend_serr; exp_herr = pend_herr;
    pend_done = 0; pend_serr = 0; pend_herr = 0;
  endtask

  function automatic logic [114:0] mkhdr(input int size, input bit vc, input int tt,
      input int ft, input logic [15:0] dst, input logic [15:0] src, input logic [28:0] addr);
    logic [114:0] h = '0;
    h[114:106] = size[8:0]; h[105] = vc; h[103:102] = 2'b11;
    h[101:100] = tt[1:0]; h[99:96] = ft[3:0];
    h[95:80] = dst; h[79:64] = src; h[63:35] = addr;
    return h;
  endfunction

  task automatic send_pkt(input logic [114:0] h, input int nbytes, input int pid,
                          input bit good, input bit serr, input bit intrude);
    int beats = (nbytes + 15) / 16;
    int empty = (beats * 16 - nbytes) / 2;
    int base  = int'(h[39:35]) * 8;
    for (int k = 0; k < beats; k++) begin
      logic [127:0] d = '0;
      bit last = (k == beats - 1);
      int nv = last ? 16 - 2 * empty : 16;
      for (int j = 0; j < 16; j++) begin
        logic [7:0] b = 8'((pid * 31 + k * 16 + j) * 7 + 3);
        d[127 - 8 * j -: 8] = b;
        if (good && j < nv) begin
          ref_mem[(base + k * 16 + j) % 256] = b;
          ref_known[(base + k * 16 + j) % 256] = 1;
        end
      end
      if (k > 0 && intrude) begin
        pl_valid = 0; hdr_valid = 1; hdr_data = h; pl_sop = 0; pl_eop = 0;
        #1 chk(hdr_ready == 0, "R2 bubble hdr_ready", hdr_ready, 0);
        step();
      end
      hdr_valid = (k == 0) || intrude; hdr_data = h;
      pl_valid = 1; pl_data = d; pl_sop = (k == 0); pl_eop = last; pl_empty = 3'(empty);
      #1;
      if (k == 0) chk(hdr_ready == 1 && pl_ready == 1, "R1 paired accept", {hdr_ready, pl_ready}, 2'b11);
      else begin
        chk(hdr_ready == 0, "R2 hdr_ready mid-packet", hdr_ready, 0);
        chk(pl_ready == 1, "R2 pl_ready mid-packet", pl_ready, 1);
      end
      if (last) begin pend_done = 1; pend_serr = serr; pend_herr = !good; end
      step();
    end
    hdr_valid = 0; pl_valid = 0; pl_sop = 0; pl_eop = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) ref_known[a] = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk(hdr_ready == 0 && pl_ready == 0, "R10 readies after reset", {hdr_ready, pl_ready}, 0);
    chk(done == 0 && size_err == 0 && hdr_err == 0, "R10 pulses after reset", {done, size_err, hdr_err}, 0);
    started = 1;
    step();

    hdr_valid = 1; hdr_data = mkhdr(16, 0, 0, 6, 16'h00DD, 16'h00AA, 29'h1);
    #1 chk(hdr_ready == 0 && pl_ready == 0, "R1 header alone", {hdr_ready, pl_ready}, 0);
    pl_valid = 1; pl_sop = 0;
    #1 chk(hdr_ready == 0 && pl_ready == 0, "R1 non-sop beat", {hdr_ready, pl_ready}, 0);
    step();
    hdr_valid = 0; pl_valid = 0;
    hdr_valid = 0; pl_valid = 1; pl_sop = 1;
    #1 chk(pl_ready == 0, "R1 payload alone", pl_ready, 0);
    step();
    pl_valid = 0; pl_sop = 0;

    send_pkt(mkhdr(40, 0, 0, 6, 16'h00DD, 16'h00AA, 29'h1), 40, 1, 1, 0, 0);   // R3 R4
    send_pkt(mkhdr(32, 0, 0, 6, 16'h00DD, 16'h00AA, 29'h10), 32, 2, 1, 0, 1);  // R2
    send_pkt(mkhdr(2, 0, 0, 6, 16'h00DD, 16'h00AA, 29'h1), 2, 3, 1, 0, 0);     // R4
    send_pkt(mkhdr(24, 0, 0, 6, 16'h00DD, 16'h00AA, 29'h1F), 24, 4, 1, 0, 0);  // R3 wrap
    send_pkt(mkhdr(40, 0, 0, 6, 16'h00DD, 16'h00AA, 29'h8), 34, 5, 1, 1, 0);   // R6
    send_pkt(mkhdr(30, 0, 0, 6, 16'h00DD, 16'h00AA, 29'hC), 32, 6, 1, 1, 0);   // R6
    send_pkt(mkhdr(32, 0, 0, 5, 16'h00DD, 16'h00AA, 29'h10), 32, 7, 0, 0, 0);  // R7
    send_pkt(mkhdr(16, 1, 0, 6, 16'h00DD, 16'h00AA, 29'h1), 16, 8, 0, 0, 0);   // R8
    send_pkt(mkhdr(16, 0, 0, 6, 16'h01DD, 16'h00AA, 29'h10), 16, 9, 0, 0, 0);  // R9
    send_pkt(mkhdr(16, 0, 0, 6, 16'h00DD, 16'h02AA, 29'h1), 16, 10, 0, 0, 0);  // R9
    send_pkt(mkhdr(16, 0, 1, 6, 16'h01DD, 16'h02AA, 29'h14), 16, 11, 1, 0, 0); // R9 tt=1
    step(); step();

    for (int a = 0; a < 256; a++) begin
      if (ref_known[a]) begin
        rd_addr = 8'(a);
        #1 chk(rd_data === ref_mem[a], "R3/R4/R7/R8/R9 via R11 read port", rd_data, ref_mem[a]);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule